// File: doc/BRIEF.md
# GPIO Port Register Block

This block holds the software-visible registers of a 16-pin general-purpose I/O port. A simple 32-bit register bus reaches it. The bus presents an address, a write strobe and write data in one cycle. Read data comes back combinationally in that same cycle. The block keeps four registers:

- a per-pin 2-bit mode field, which drives the port's configuration outputs;
- a read-only view of the input pins, taken after a two-flop synchronizer;
- a read-write output data register, which drives the output pins;
- a write-only set/clear register. One write to it raises some output bits and lowers others, so software needs no read-modify-write and other pins are never disturbed.

A port enable input gates every access. While it is low, reads return zero and writes are lost. The registers keep their contents while the enable is low.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, every mode field and every output data bit is zero, and reads of those registers return zero.
- R2: A write at byte offset 0x00 loads the mode register, and a read there returns the last value written. Pin n owns bits [2n+1:2n], and code 2'b01 in a field means general-purpose output. The whole register appears on `pin_mode`.
- R3: A write at offset 0x14 loads the output data register from bits [15:0]. A read there returns the register in bits [15:0] and zero above. The register appears on `pin_out`.
- R4: A read at offset 0x10 returns the input pins as they stood two clock edges earlier, in bits [15:0]. A write to offset 0x10 changes no register.
- R5: A write at offset 0x18 sets output bit n when data bit n is 1 (n in 0..15). It clears output bit n when data bit n+16 is 1. Output bits whose two data bits are both 0 keep their value. The update takes effect on the clock edge of the write.
- R6: If one write at offset 0x18 has both the set bit and the clear bit of the same pin at 1, that pin ends up at 1.
- R7: A read at offset 0x18 always returns zero.
- R8: While `port_en` is 0, every read returns zero and no write changes any register. Contents written earlier come back once `port_en` returns to 1.
- R9: A read at any offset other than 0x00, 0x10, 0x14 or 0x18 returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | 1 | Port clock enable; gates all bus access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pin_in | input | 16 | Asynchronous input pin levels |
| pin_out | output | 16 | Output data register |
| pin_mode | output | 32 | Mode register, 2 bits per pin |

## Verification
Read data is combinational. The bench therefore compares `bus_rdata` a few nanoseconds after it drives the inputs, and before the next rising edge. A write shows on `pin_out` and `pin_mode`, and in later reads, after exactly one rising edge. The bench checks those outputs on the falling edge that follows the write. Pin changes reach the input register after two edges, so the reference model keeps a two-deep history of the pins it drove. Every read at offset 0x10 is compared against the oldest entry of that history.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO port register block.
// Assumes byte offsets that fit in 8 bits; the top widens them to its address width.
package gpio_port_pkg;
    localparam int unsigned GP_PINS   = 16;
    localparam int unsigned GP_MODE_W = 2;

    localparam logic [7:0] OFS_MODE = 8'h00;
    localparam logic [7:0] OFS_IN   = 8'h10;
    localparam logic [7:0] OFS_OUT  = 8'h14;
    localparam logic [7:0] OFS_SETC = 8'h18;

    // One-hot register selection decoded from the bus address.
    typedef struct packed {
        logic mode;
        logic in;
        logic out;
        logic setc;
    } gp_sel_t;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous input pins.
// Assumes each pin is sampled independently; multi-bit coherence is not needed.
module gpio_in_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    // Shift pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    // Count edges since reset so the lag check starts only once history exists.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign dout = stage2_q;

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2))); // R4
endmodule

// File: rtl/gpio_mode_reg.sv
// Read-write mode register: 2 bits per pin, loaded whole by a gated write.
// Assumes the caller has already qualified wr with the port enable and the address.
module gpio_mode_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold or load the mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr)) |-> (q == $past(wdata))); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr)) |-> $stable(q)); // R8
endmodule

// File: rtl/gpio_out_reg.sv
// Output data register with two write paths: a whole-register load and a
// per-bit set/clear update in which set takes precedence over clear.
// Assumes at most one of wr_load and wr_setc is high in a cycle.
module gpio_out_reg #(
    parameter int unsigned PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_load,
    input  logic [PINS-1:0] load_data,
    input  logic            wr_setc,
    input  logic [PINS-1:0] set_mask,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] q
);
    logic [PINS-1:0] q_next;

    // Select the next output value from the active write path.
    always_comb begin
        q_next = q;
        if (wr_load)      q_next = load_data;
        else if (wr_setc) q_next = (q & ~clr_mask) | set_mask;
    end

    // Register the output data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    AST_SETC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_setc)) |-> ((q & $past(set_mask)) == $past(set_mask))); // R6
    AST_SETC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_setc)) |-> ((q & $past(clr_mask & ~set_mask)) == '0)); // R5
    AST_SETC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_setc)) |->
        ((q & ~$past(set_mask | clr_mask)) == ($past(q) & ~$past(set_mask | clr_mask)))); // R5
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_load) && !$past(wr_setc)) |-> $stable(q)); // R8
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_load && wr_setc)); // R5
endmodule

// File: rtl/gpio_port_regs.sv
// GPIO port register block: address decode, enable gating and read mux around
// the mode, input, output and set/clear registers.
// Assumes a single-cycle bus with combinational read data, and DATA_W >= 2*PINS.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS   = GP_PINS,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  port_en,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [PINS-1:0]       pin_in,
    output logic [PINS-1:0]       pin_out,
    output logic [PINS*GP_MODE_W-1:0] pin_mode
);
    localparam int unsigned MODE_BITS = PINS * GP_MODE_W;

    gp_sel_t         sel;
    logic            wr_ok;
    logic [PINS-1:0] in_sync;

    // Decode the bus address into a register selection.
    always_comb begin
        sel      = '0;
        sel.mode = (bus_addr == ADDR_W'(OFS_MODE));
        sel.in   = (bus_addr == ADDR_W'(OFS_IN));
        sel.out  = (bus_addr == ADDR_W'(OFS_OUT));
        sel.setc = (bus_addr == ADDR_W'(OFS_SETC));
    end

    assign wr_ok = port_en & bus_wr;

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (in_sync)
    );

    gpio_mode_reg #(.W(MODE_BITS)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ok & sel.mode),
        .wdata (bus_wdata[MODE_BITS-1:0]),
        .q     (pin_mode)
    );

    gpio_out_reg #(.PINS(PINS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_load   (wr_ok & sel.out),
        .load_data (bus_wdata[PINS-1:0]),
        .wr_setc   (wr_ok & sel.setc),
        .set_mask  (bus_wdata[PINS-1:0]),
        .clr_mask  (bus_wdata[PINS +: PINS]),
        .q         (pin_out)
    );

    // Return the selected register, or zero when disabled or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (port_en) begin
            if (sel.mode)     bus_rdata[MODE_BITS-1:0] = pin_mode;
            else if (sel.in)  bus_rdata[PINS-1:0]      = in_sync;
            else if (sel.out) bus_rdata[PINS-1:0]      = pin_out;
        end
    end

    AST_DISABLED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (bus_rdata == '0)); // R8
    AST_SETC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sel.setc |-> (bus_rdata == '0)); // R7
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R9
endmodule

// File: tb/gpio_port_regs_tb.sv
// Bench with a behavioural reference model that is stepped and compared every cycle.
module gpio_port_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        port_en;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in;
    logic [15:0] pin_out;
    logic [31:0] pin_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state.
    logic [31:0] m_mode;
    logic [15:0] m_out;
    logic [15:0] m_hist1, m_hist2;

    always #10 clk = ~clk;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_mode(pin_mode)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic en, input logic [7:0] a);
        if (!en) return 32'h0;
        case (a)
            8'h00:   return m_mode;
            8'h10:   return {16'h0, m_hist2};
            8'h14:   return {16'h0, m_out};
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive at the falling edge, compare read data, clock, compare outputs.
    task automatic step(input string tag, input logic rst, input logic en, input logic [7:0] a,
                        input logic wr, input logic [31:0] wd, input logic [15:0] pins);
        rst_n = rst; port_en = en; bus_addr = a; bus_wr = wr; bus_wdata = wd; pin_in = pins;
        #3;
        if (rst) check(tag, "rdata", bus_rdata, model_read(en, a));
        @(posedge clk);
        if (!rst) begin
            m_mode = '0; m_out = '0; m_hist1 = '0; m_hist2 = '0;
        end else begin
            m_hist2 = m_hist1;
            m_hist1 = pins;
            if (en && wr) begin
                case (a)
                    8'h00: m_mode = wd;
                    8'h14: m_out = wd[15:0];
                    8'h18: m_out = (m_out & ~wd[31:16]) | wd[15:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        check(tag, "pin_out", {16'h0, pin_out}, {16'h0, m_out});
        check(tag, "pin_mode", pin_mode, m_mode);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_mode = '0; m_out = '0; m_hist1 = '0; m_hist2 = '0;
        rst_n = 1'b0; port_en = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b1, 8'h00, 1'b1, 32'hFFFF_FFFF, 16'hFFFF);
        step("R1", 1'b1, 1'b1, 8'h00, 1'b0, 32'h0, 16'h0);
        step("R1", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        // R2: mode write and readback, code 01 marks pin 0 as output
        step("R2", 1'b1, 1'b1, 8'h00, 1'b1, 32'h5555_0001, 16'h0);
        step("R2", 1'b1, 1'b1, 8'h00, 1'b0, 32'h0, 16'h0);
        step("R2", 1'b1, 1'b1, 8'h00, 1'b1, 32'hA0F0_3C01, 16'h0);
        step("R2", 1'b1, 1'b1, 8'h00, 1'b0, 32'h0, 16'h0);
        // R3: output data, upper write bits dropped
        step("R3", 1'b1, 1'b1, 8'h14, 1'b1, 32'hFFFF_A5A5, 16'h0);
        step("R3", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        step("R3", 1'b1, 1'b1, 8'h14, 1'b1, 32'h0000_1234, 16'h0);
        step("R3", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        // R4: input pins with two-edge lag, varied patterns
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'hBEEF);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h0F0F);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h8001);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'hFFFF);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'hFFFF);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b1, 32'h0000_FFFF, 16'h0000);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h0000);
        step("R4", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h0000);
        step("R4", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0000);
        // R5: set and clear in one write, untouched bits kept
        step("R5", 1'b1, 1'b1, 8'h18, 1'b1, 32'h00F0_000F, 16'h0);
        step("R5", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        step("R5", 1'b1, 1'b1, 8'h18, 1'b1, 32'h1000_8000, 16'h0);
        step("R5", 1'b1, 1'b1, 8'h18, 1'b1, 32'h0000_0000, 16'h0);
        step("R5", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        // R6: set wins over clear on the same pin
        step("R6", 1'b1, 1'b1, 8'h18, 1'b1, 32'hFFFF_0001, 16'h0);
        step("R6", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        // R7: set/clear register reads zero
        step("R7", 1'b1, 1'b1, 8'h18, 1'b0, 32'h0, 16'h0);
        step("R7", 1'b1, 1'b1, 8'h18, 1'b0, 32'h0, 16'h1234);
        // R8: disabled port drops writes and reads zero, contents retained
        step("R8", 1'b1, 1'b0, 8'h14, 1'b1, 32'h0000_FFFF, 16'h5A5A);
        step("R8", 1'b1, 1'b0, 8'h00, 1'b1, 32'h1234_5678, 16'h5A5A);
        step("R8", 1'b1, 1'b0, 8'h18, 1'b1, 32'h0000_FFFF, 16'h5A5A);
        step("R8", 1'b1, 1'b0, 8'h00, 1'b0, 32'h0, 16'h5A5A);
        step("R8", 1'b1, 1'b0, 8'h10, 1'b0, 32'h0, 16'h5A5A);
        step("R8", 1'b1, 1'b1, 8'h00, 1'b0, 32'h0, 16'h5A5A);
        step("R8", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h5A5A);
        step("R8", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h5A5A);
        // R9: unmapped offsets
        step("R9", 1'b1, 1'b1, 8'h04, 1'b1, 32'hFFFF_FFFF, 16'h0);
        step("R9", 1'b1, 1'b1, 8'h1C, 1'b1, 32'hFFFF_FFFF, 16'h0);
        step("R9", 1'b1, 1'b1, 8'h15, 1'b1, 32'hFFFF_FFFF, 16'h0);
        step("R9", 1'b1, 1'b1, 8'h04, 1'b0, 32'h0, 16'h0);
        step("R9", 1'b1, 1'b1, 8'hFC, 1'b0, 32'h0, 16'h0);
        step("R9", 1'b1, 1'b1, 8'h14, 1'b0, 32'h0, 16'h0);
        // R1: reset again mid-run
        step("R1", 1'b0, 1'b1, 8'h00, 1'b0, 32'h0, 16'hFFFF);
        step("R1", 1'b1, 1'b1, 8'h00, 1'b0, 32'h0, 16'h0);
        step("R1", 1'b1, 1'b1, 8'h10, 1'b0, 32'h0, 16'h0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule